// File: doc/BRIEF.md
# Double-Buffered Recirculating Coefficient Store

This block holds the coefficient set for a synthesis core in two shift banks of equal size. The host writes bytes one at a time into a load bank. Each write pushes the byte into the entry stage and moves every older byte one stage toward the exit. A playback bank holds the coefficients of the current frame. The consumer rotates this bank past a single output tap. The byte leaving the last stage re-enters at the first, so the same set can be played out any number of times.

A frame pulse copies the whole load bank into the playback bank in one cycle. The host can then fill the load bank with the next frame's set while the current set keeps playing. A load counter reports how many bytes have arrived since the last frame pulse. A sticky flag records any write that found the load bank already full.

Top module: `coef_dbuf_fifo`

## Requirements
- R1: While rst_ni is low, both banks, the load count and the overflow flag clear, so tap_o = 0, load_cnt_o = 0 and ovf_o = 0.
- R2: A write accepted while load_cnt_o < 15 places wr_data_i in load stage 0, moves load stage k-1 to stage k, and raises load_cnt_o by one on the next edge.
- R3: Without an accepted write the load bank keeps its contents unchanged, however many cycles pass.
- R4: On a frame pulse all 15 load stages are copied in parallel into the playback bank. After 15 writes, tap_o on the next cycle shows the first of those 15 bytes (load stage 14).
- R5: A playback shift without a frame pulse moves playback stage k-1 to stage k and feeds stage 14 back into stage 0. tap_o always shows stage 14, so after 15 shifts the original byte is back at the tap.
- R6: Playback shifts leave the load bank unchanged, and host writes do not change tap_o.
- R7: A write while load_cnt_o = 15 and no frame pulse is ignored. load_cnt_o stays 15 and ovf_o rises and stays high.
- R8: A frame pulse clears ovf_o and restarts the load count. A write in the same cycle is the first byte of the new frame (load_cnt_o = 1), and the playback bank receives the load bank as it stood before that write.
- R9: When a frame pulse and a playback shift come in the same cycle, the frame copy wins and no rotation takes place.
- R10: With no shift and no frame pulse, tap_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write byte |
| frame_i | input | 1 | Frame-start pulse |
| shift_i | input | 1 | Playback rotate enable |
| tap_o | output | 8 | Playback stage 14 |
| load_cnt_o | output | 4 | Bytes accepted since last frame pulse |
| ovf_o | output | 1 | Sticky flag for a write while full |

## Verification
Every output is taken straight from registers. The result of a stimulus driven before an edge therefore appears exactly one edge later, for tap_o, load_cnt_o and ovf_o alike. The driver applies one stimulus per cycle and pushes the expected triple, which a reference model predicts from the requirements. The monitor pops that triple 2 ns after the following rising edge. Idle gaps push nothing, so a check is made only in the cycle its result is due. Every expectation is therefore aligned to the single register stage.

// File: rtl/coef_pkg.sv
package coef_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned DEPTH_DEF  = 15;

  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/coef_load_bank.sv
module coef_load_bank #(
  parameter int unsigned DATA_W = coef_pkg::DATA_W_DEF,
  parameter int unsigned DEPTH  = coef_pkg::DEPTH_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] bank_o [DEPTH]
);
  logic [DATA_W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else if (push_i) stage_q[0] <= din_i;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else if (push_i) stage_q[g] <= stage_q[g-1];
    end

    // R3: no push, no movement
    a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !push_i |=> $stable(stage_q[g]));
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign bank_o[g] = stage_q[g];
  end

  a_r2_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> stage_q[0] == $past(din_i));
endmodule

// File: rtl/coef_play_bank.sv
module coef_play_bank #(
  parameter int unsigned DATA_W = coef_pkg::DATA_W_DEF,
  parameter int unsigned DEPTH  = coef_pkg::DEPTH_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rot_i,
  input  logic [DATA_W-1:0] load_data_i [DEPTH],
  output logic [DATA_W-1:0] tap_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DATA_W-1:0] stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [DATA_W-1:0] feed;
    if (g == 0) begin : g_wrap
      assign feed = stage_q[LAST];
    end else begin : g_chain
      assign feed = stage_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else if (load_i) stage_q[g] <= load_data_i[g];
      else if (rot_i) stage_q[g] <= feed;
    end
  end

  assign tap_o = stage_q[LAST];

  a_r5_recirc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rot_i && !load_i |=> stage_q[0] == $past(stage_q[LAST]));
  a_r9_copy_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> tap_o == $past(load_data_i[LAST]));
  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !rot_i |=> $stable(tap_o));
endmodule

// File: rtl/coef_load_ctr.sv
module coef_load_ctr #(
  parameter int unsigned DEPTH = coef_pkg::DEPTH_DEF,
  parameter int unsigned CNT_W = coef_pkg::cnt_width(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             frame_i,
  output logic             accept_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             full;

  assign full     = (cnt_q == FULL);
  assign accept_o = wr_en_i && (frame_i || !full);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (frame_i) begin
      cnt_q <= wr_en_i ? CNT_W'(1) : '0;
      ovf_q <= 1'b0;
    end else begin
      if (accept_o) cnt_q <= cnt_q + CNT_W'(1);
      if (wr_en_i && full) ovf_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !frame_i && cnt_q == FULL |=> ovf_q && cnt_q == FULL);
  a_r7_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> !ovf_q && cnt_q <= CNT_W'(1));
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !frame_i |=> ovf_q);
endmodule

// File: rtl/coef_dbuf_fifo.sv
module coef_dbuf_fifo #(
  parameter int unsigned DATA_W = coef_pkg::DATA_W_DEF,
  parameter int unsigned DEPTH  = coef_pkg::DEPTH_DEF,
  localparam int unsigned CNT_W = coef_pkg::cnt_width(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              frame_i,
  input  logic              shift_i,
  output logic [DATA_W-1:0] tap_o,
  output logic [CNT_W-1:0]  load_cnt_o,
  output logic              ovf_o
);
  logic              accept;
  logic [DATA_W-1:0] load_bank [DEPTH];

  coef_load_ctr #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .frame_i  (frame_i),
    .accept_o (accept),
    .cnt_o    (load_cnt_o),
    .ovf_o    (ovf_o)
  );

  coef_load_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_load (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (accept),
    .din_i  (wr_data_i),
    .bank_o (load_bank)
  );

  coef_play_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_play (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (frame_i),
    .rot_i       (shift_i),
    .load_data_i (load_bank),
    .tap_o       (tap_o)
  );

  // R6: writes alone never disturb the tap
  a_r6_write_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i && !shift_i |=> $stable(tap_o));
endmodule

// File: tb/test_coef_dbuf_fifo.sv
module test_coef_dbuf_fifo;
  localparam int N = 15;

  typedef struct {
    logic [7:0] tap;
    logic [3:0] cnt;
    logic       ovf;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       frame = 1'b0;
  logic       shift = 1'b0;
  logic [7:0] tap;
  logic [3:0] cnt;
  logic       ovf;

  int checks = 0;
  int errors = 0;
  exp_t sb_q[$];

  logic [7:0] m_in [N];
  logic [7:0] m_pb [N];
  int         m_cnt = 0;
  bit         m_ovf = 1'b0;

  always #4 clk = ~clk;

  coef_dbuf_fifo i_coef_dbuf_fifo (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .frame_i(frame), .shift_i(shift), .tap_o(tap), .load_cnt_o(cnt), .ovf_o(ovf)
  );

  task automatic cmp(input string tag, input logic [7:0] t, input logic [3:0] c, input logic o);
    checks++;
    if (tap !== t || cnt !== c || ovf !== o) begin
      errors++;
      $display("FAIL %s: tap=%h cnt=%0d ovf=%b expected tap=%h cnt=%0d ovf=%b",
               tag, tap, cnt, ovf, t, c, o);
    end
  endtask

  // monitor: result due one edge after the stimulus
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      cmp(e.tag, e.tap, e.cnt, e.ovf);
    end
  end

  task automatic step(input bit wr, input logic [7:0] d, input bit fr, input bit sh, input string tag);
    exp_t e;
    logic [7:0] last;
    @(negedge clk);
    wr_en = wr; wr_data = d; frame = fr; shift = sh;
    if (fr) begin
      for (int k = 0; k < N; k++) m_pb[k] = m_in[k];
      m_cnt = 0;
      m_ovf = 1'b0;
    end else if (sh) begin
      last = m_pb[N-1];
      for (int k = N-1; k > 0; k--) m_pb[k] = m_pb[k-1];
      m_pb[0] = last;
    end
    if (wr) begin
      if (m_cnt < N) begin
        for (int k = N-1; k > 0; k--) m_in[k] = m_in[k-1];
        m_in[0] = d;
        m_cnt++;
      end else begin
        m_ovf = 1'b1;
      end
    end
    e.tap = m_pb[N-1]; e.cnt = 4'(m_cnt); e.ovf = m_ovf; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 0; frame = 0; shift = 0;
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin m_in[k] = '0; m_pb[k] = '0; end
    fork
      begin
        repeat (3) @(negedge clk);
        cmp("R1", 8'h00, 4'd0, 1'b0);
        rst_n = 1'b1;
        // R2: fill load bank
        for (int i = 0; i < N; i++) step(1, 8'h10 + 8'(i), 0, 0, "R2");
        // R3: idle gap, load bank must hold
        repeat (4) idle();
        // R4: parallel copy, tap = first byte written
        step(0, 8'h00, 1, 0, "R4");
        // R5/R6: rotate while loading the next set
        for (int i = 0; i < N; i++) step(1, 8'hA0 + 8'(i), 0, 1, "R5");
        step(0, 8'h00, 0, 1, "R6");
        // R7: writes while full are dropped
        step(1, 8'hEE, 0, 0, "R7");
        step(1, 8'hEF, 0, 1, "R7");
        repeat (2) step(0, 8'h00, 0, 0, "R10");
        // R8/R9: frame with write and shift in same cycle
        step(1, 8'h55, 1, 1, "R9");
        step(0, 8'h00, 0, 0, "R8");
        for (int i = 0; i < N; i++) step(0, 8'h00, 0, 1, "R5");
        repeat (3) step(0, 8'h00, 0, 0, "R10");
        // R3: partial load then frame exposes held contents
        for (int i = 0; i < 3; i++) step(1, 8'hC0 + 8'(i), 0, 0, "R3");
        repeat (3) idle();
        step(0, 8'h00, 1, 0, "R3");
        for (int i = 0; i < N; i++) step(0, 8'h00, 0, 1, "R6");
        repeat (3) @(negedge clk);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule